// File: doc/BRIEF.md
# Event-Blink Status LED Controller

This block drives a single status LED from three synchronous control inputs. A level input picks the resting behaviour. When it is high the LED stays lit. When it is low the LED copies a slow square wave supplied from outside, usually one that flips once a second. A one-cycle activity strobe, such as the start of a packet, makes the LED go dark for a fixed time. The LED is then held lit for a guaranteed minimum time, so a dense stream of activity still reads as a visible blink rather than a dim glow.

Every interval is measured in pulses of an external millisecond strobe, not in raw clock cycles. The length `HOLD_MS` is a parameter: around 100 on hardware, and a small value for fast runs. Activity that arrives while a dark or hold window is running is remembered in a single pending flag. When the hold window ends, that flag starts a fresh dark window at once.

Top module: `blink_led_ctrl`

## Requirements
- R1: With no blink window running and `on_level` high, the registered `led` output is 1 one clock after the inputs are sampled.
- R2: With no blink window running and `on_level` low, `led` equals the value `slow_wave` had at the previous rising clock edge.
- R3: An `evt_strobe` sampled while no window is running drives `led` to 0 at that same clock edge.
- R4: The dark window ends at the clock edge that samples its `HOLD_MS`-th `ms_tick`. A tick sampled in the same cycle as the starting event is not counted. Ticks are counted from the first one sampled after entry.
- R5: After the dark window, `led` is 1 for `HOLD_MS` ticks, whatever the values of `on_level` and `slow_wave`.
- R6: An event sampled during a dark or hold window is kept pending. At the end of the hold window, including the edge that samples the final tick, the block enters a new dark window instead of going idle.
- R7: Any number of events inside one dark-plus-hold cycle schedule exactly one further dark window.
- R8: With nothing pending, the end of the hold window returns `led` to the value chosen by `on_level` (R1, R2).
- R9: Clock cycles without `ms_tick` never advance a window: `led` holds its value for as long as ticks are absent.
- R10: A high synchronous `rst` ends any window and clears the pending flag. During reset, `led` follows the R1/R2 selection, and an event sampled during reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| on_level | input | 1 | 1 = steady lit at rest, 0 = follow `slow_wave` |
| slow_wave | input | 1 | Slow square wave copied while resting in follow mode |
| evt_strobe | input | 1 | One-cycle activity event |
| led | output | 1 | Registered LED drive, 1 = lit |

## Verification
On every cycle the assertions check the following. The LED is dark exactly in the dark window and lit throughout the hold window. A resting block obeys the mode selection and goes dark on an event. The window state never moves in a cycle that has neither a tick nor an event. An event seen during the hold window is never lost. The tick counter never reaches `HOLD_MS`. Reset always returns the block to rest with nothing pending. Only the bench scenarios show the full timing: the dark and hold windows last exactly `HOLD_MS` ticks, a burst of events collapses into a single extra window, an event that lands on the final tick restarts the dark window, and activity seen during reset or cut off by reset leaves no trace.

// File: rtl/blink_led_pkg.sv
package blink_led_pkg;

    // Window phase of the blink sequencer.
    typedef enum logic [1:0] {
        BL_REST = 2'd0,
        BL_DARK = 2'd1,
        BL_HOLD = 2'd2
    } blink_state_e;

    // Registered state of the sequencer: phase plus the pending-event flag.
    typedef struct packed {
        blink_state_e state;
        logic         pend;
    } seq_regs_t;

endpackage

// File: rtl/ms_window_cnt.sv
module ms_window_cnt #(
    parameter int HOLD_MS = 100,
    parameter int CNT_W   = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_MS - 1);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        expire = run && tick && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run && tick) begin
            cnt_d = cnt_q + 1'b1;
        end
        if (rst) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/blink_seq.sv
module blink_seq
    import blink_led_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         evt,
    input  logic         expire,
    output blink_state_e state_q,
    output blink_state_e state_d,
    output logic         pend_q,
    output logic         restart,
    output logic         run
);

    seq_regs_t r_q;
    seq_regs_t r_d;

    always_comb begin
        r_d     = r_q;
        restart = 1'b0;
        unique case (r_q.state)
            BL_REST: begin
                if (evt) begin
                    r_d.state = BL_DARK;
                    restart   = 1'b1;
                end
            end
            BL_DARK: begin
                r_d.pend = r_q.pend | evt;
                if (expire) begin
                    r_d.state = BL_HOLD;
                    restart   = 1'b1;
                end
            end
            BL_HOLD: begin
                r_d.pend = r_q.pend | evt;
                if (expire) begin
                    restart = 1'b1;
                    if (r_q.pend | evt) begin
                        r_d.state = BL_DARK;
                        r_d.pend  = 1'b0;
                    end else begin
                        r_d.state = BL_REST;
                    end
                end
            end
            default: begin
                r_d.state = BL_REST;
                r_d.pend  = 1'b0;
            end
        endcase
        if (rst) begin
            r_d.state = BL_REST;
            r_d.pend  = 1'b0;
            restart   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state_q = r_q.state;
    assign state_d = r_d.state;
    assign pend_q  = r_q.pend;
    assign run     = (r_q.state != BL_REST);

endmodule

// File: rtl/led_drive.sv
module led_drive
    import blink_led_pkg::*;
(
    input  logic         clk,
    input  blink_state_e state_nxt,
    input  logic         on_level,
    input  logic         slow_wave,
    output logic         led_q
);

    logic led_d;

    always_comb begin
        unique case (state_nxt)
            BL_DARK: led_d = 1'b0;
            BL_HOLD: led_d = 1'b1;
            default: led_d = on_level | slow_wave;
        endcase
    end

    always_ff @(posedge clk) begin
        led_q <= led_d;
    end

endmodule

// File: rtl/blink_led_ctrl.sv
module blink_led_ctrl
    import blink_led_pkg::*;
#(
    parameter int HOLD_MS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic on_level,
    input  logic slow_wave,
    input  logic evt_strobe,
    output logic led
);

    localparam int CNT_W = (HOLD_MS > 1) ? $clog2(HOLD_MS) : 1;

    blink_state_e     seq_state;
    blink_state_e     seq_next;
    logic             seq_pend;
    logic             win_restart;
    logic             win_run;
    logic             win_expire;
    logic [CNT_W-1:0] win_cnt;

    ms_window_cnt #(
        .HOLD_MS (HOLD_MS),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (win_restart),
        .run     (win_run),
        .tick    (ms_tick),
        .cnt_q   (win_cnt),
        .expire  (win_expire)
    );

    blink_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_strobe),
        .expire  (win_expire),
        .state_q (seq_state),
        .state_d (seq_next),
        .pend_q  (seq_pend),
        .restart (win_restart),
        .run     (win_run)
    );

    led_drive u_drv (
        .clk       (clk),
        .state_nxt (seq_next),
        .on_level  (on_level),
        .slow_wave (slow_wave),
        .led_q     (led)
    );

endmodule

// File: rtl/blink_led_ctrl_chk.sv
module blink_led_ctrl_chk
    import blink_led_pkg::*;
#(
    parameter int HOLD_MS = 100,
    parameter int CNT_W   = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             ms_tick,
    input logic             on_level,
    input logic             slow_wave,
    input logic             evt_strobe,
    input logic             led,
    input blink_state_e     state,
    input logic             pend,
    input logic [CNT_W-1:0] cnt
);

    // R1: resting, steady mode, no event -> lit next cycle
    p_rest_on_r1: assert property (@(posedge clk) disable iff (rst)
        (state == BL_REST && !evt_strobe && on_level) |=> led);

    // R2: resting, follow mode -> copy of the sampled wave
    p_rest_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (state == BL_REST && !evt_strobe && !on_level) |=> (led == $past(slow_wave)));

    // R3: event at rest -> dark
    p_event_dark_r3: assert property (@(posedge clk) disable iff (rst)
        (state == BL_REST && evt_strobe) |=> !led);

    // R4: dark window means dark LED
    p_dark_window_r4: assert property (@(posedge clk) disable iff (rst)
        (state == BL_DARK) |-> !led);

    // R4: counter stays inside the window length
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(HOLD_MS));

    // R5: hold window means lit LED
    p_hold_lit_r5: assert property (@(posedge clk) disable iff (rst)
        (state == BL_HOLD) |-> led);

    // R6: an event in the hold window is never dropped
    p_hold_event_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (state == BL_HOLD && evt_strobe) |=> (pend || state == BL_DARK));

    // R9: no tick and no event -> window phase does not move
    p_no_tick_still_r9: assert property (@(posedge clk) disable iff (rst)
        (state != BL_REST && !ms_tick && !evt_strobe) |=> $stable(state));

    // R10: reset returns to rest with nothing pending
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (state == BL_REST && !pend));

endmodule

bind blink_led_ctrl blink_led_ctrl_chk #(
    .HOLD_MS (HOLD_MS),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ms_tick    (ms_tick),
    .on_level   (on_level),
    .slow_wave  (slow_wave),
    .evt_strobe (evt_strobe),
    .led        (led),
    .state      (seq_state),
    .pend       (seq_pend),
    .cnt        (win_cnt)
);

// File: tb/blink_led_ctrl_tb.sv
module blink_led_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 3;

    logic clk        = 1'b0;
    logic rst        = 1'b1;
    logic ms_tick    = 1'b0;
    logic on_level   = 1'b0;
    logic slow_wave  = 1'b0;
    logic evt_strobe = 1'b0;
    logic led;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    // Reference model: 0 = rest, 1 = dark, 2 = hold
    int m_mode = 0;
    int m_left = 0;
    bit m_pend = 1'b0;

    blink_led_ctrl #(.HOLD_MS(HOLD)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .ms_tick    (ms_tick),
        .on_level   (on_level),
        .slow_wave  (slow_wave),
        .evt_strobe (evt_strobe),
        .led        (led)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply one cycle of inputs and push the expected LED value.
    task automatic step(input bit r, input bit on, input bit wv, input bit ev,
                        input bit tk, input string tag);
        logic e;
        @(negedge clk);
        rst = r; on_level = on; slow_wave = wv; evt_strobe = ev; ms_tick = tk;
        if (r) begin
            m_mode = 0; m_left = 0; m_pend = 1'b0;
        end else if (m_mode == 0) begin
            if (ev) begin m_mode = 1; m_left = HOLD; end
        end else begin
            if (ev) m_pend = 1'b1;
            if (tk) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_mode == 1) begin
                        m_mode = 2; m_left = HOLD;
                    end else if (m_pend) begin
                        m_mode = 1; m_left = HOLD; m_pend = 1'b0;
                    end else begin
                        m_mode = 0;
                    end
                end
            end
        end
        e = (m_mode == 1) ? 1'b0 : (m_mode == 2) ? 1'b1 : (on | wv);
        sb.push_back('{e, tag});
    endtask

    // Run n cycles; events at the cycles set in ev_mask; a tick every period cycles.
    task automatic run(input int n, input bit on, input int period,
                       input logic [63:0] ev_mask, input string tag);
        for (int c = 0; c < n; c++) begin
            step(1'b0, on, ((c / 4) % 2) == 1, (c < 64) && ev_mask[c % 64],
                 (period > 0) && (c % period == period - 1), tag);
        end
    endtask

    // Monitor: compare one quarter period after each rising edge.
    always @(posedge clk) begin
        item_t it;
        #(CLK_PERIOD/4);
        if (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (led !== it.exp) begin
                fails++;
                $display("FAIL %s: led=%0b expected=%0b at %0t", it.tag, led, it.exp, $time);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R10: reset state follows the mode selection; an event in reset is ignored
        step(1, 1, 0, 0, 0, "R10");
        step(1, 1, 0, 0, 0, "R10");
        step(1, 0, 0, 0, 0, "R10");
        step(1, 0, 1, 1, 1, "R10");
        step(0, 0, 1, 0, 0, "R10");
        // R1: steady lit at rest, whatever the wave does
        run(8, 1, 0, 64'h0, "R1");
        // R2: follow the wave at rest
        run(16, 0, 0, 64'h0, "R2");
        // R3 then R4/R5 windows with ticks every 4 cycles, R8 return to follow mode
        run(1, 0, 0, 64'h1, "R3");
        run(12, 0, 4, 64'h0, "R4");
        run(12, 1, 4, 64'h0, "R5");
        run(12, 0, 4, 64'h0, "R8");
        // R9: no ticks, the dark window must not end
        run(30, 1, 0, 64'h1, "R9");
        run(30, 1, 4, 64'h0, "R9");
        // R4 boundary: event in the same cycle as a tick, tick not counted
        run(40, 1, 4, 64'h8, "R4");
        // R6: event in the dark window re-arms after the hold window
        run(60, 0, 4, 64'h21, "R6");
        // R6 boundary: event on the final tick of the hold window
        run(60, 1, 4, (64'h1 | (64'h1 << 23)), "R6");
        // R7: a burst of events yields only one extra window
        run(70, 1, 4, 64'h108225, "R7");
        // R10: reset cancels a running window and its pending event
        run(6, 0, 4, 64'h5, "R10");
        step(1, 1, 0, 0, 0, "R10");
        run(20, 0, 4, 64'h0, "R10");
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule